// File: doc/BRIEF.md
# Power Sequencing Reset Controller

This block produces the active-low processor reset and the active-low non-maskable interrupt request of a processor subsystem from a few supply-status inputs. When power comes up, reset stays asserted until the supply-good input has been stable for a programmable number of clocks. This gives the rest of the system time to settle before the processor starts its power-up routine. When the power switch turns off, the block raises the interrupt request so that firmware can shut the system down in an orderly way.

At the end of that shutdown, firmware writes a power-down bit. The block then locks reset asserted, so the processor cannot restart while the rails decay. The lock clears only once supply-good has gone away, and the next power-up runs the full delay again. A diagnostic strap blocks the power-down bit from reaching reset, so the processor can keep running a test loop while that bit is high. All other reset causes still act while the strap is set.

A clocked counter takes the place of analog sensing and timing parts. The supply-good and power-switch inputs are asynchronous and pass through a two-stage synchroniser. The power-down bit and the strap are taken as synchronous to the clock.

Top module: `pwr_seq_rst`

## Requirements
- R1: While `arst_n` is low, and afterwards until a power-up delay has completed, `cpu_rst_no` is 0 and `nmi_no` is 1.
- R2: When `supply_ok_i` rises and then stays high, `cpu_rst_no` stays 0 for the first DELAY_CYCLES+2 rising clock edges. It becomes 1 after edge DELAY_CYCLES+3 (two synchroniser stages, one state entry, DELAY_CYCLES counted clocks).
- R3: If `supply_ok_i` goes low during the count, even for a single clock, the count is discarded. Release then comes exactly DELAY_CYCLES+3 edges after the input rises again.
- R4: While reset is released, `nmi_no` goes to 0 after the second rising edge following a fall of `pwr_sw_on_i`. It stays 0 while that input stays low and returns to 1 after the second edge following its rise.
- R5: While reset is released and `diag_strap_i` is 0, driving `sw_pd_i` to 1 pulls `cpu_rst_no` to 0 in the same clock cycle, before any clock edge.
- R6: Once `sw_pd_i` has been 1 at a rising edge with the strap at 0, `cpu_rst_no` stays 0 for as long as supply-good stays high. This holds even if `sw_pd_i` returns to 0.
- R7: The lock from R6 ends only when supply-good goes low. A later rise of `supply_ok_i` then releases reset after the full delay of R2.
- R8: While `diag_strap_i` is 1, `sw_pd_i` has no effect and `cpu_rst_no` stays 1.
- R9: With reset released, and with the strap at either value, a fall of `supply_ok_i` drives `cpu_rst_no` to 0 after the third rising edge following the fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| arst_n | input | 1 | Asynchronous active-low initialisation of all flops |
| supply_ok_i | input | 1 | Asynchronous supply-good indication, high when rails are in range |
| pwr_sw_on_i | input | 1 | Asynchronous power-switch status, high while switched on |
| sw_pd_i | input | 1 | Power-down bit written by firmware, active high |
| diag_strap_i | input | 1 | Diagnostic strap, high blocks the power-down reset path |
| cpu_rst_no | output | 1 | Active-low processor reset |
| nmi_no | output | 1 | Active-low non-maskable interrupt request |

## Verification
The power-up delay is exercised three ways, and each release time is compared edge by edge against the DELAY_CYCLES+3 rule:
- a clean rise from the off state;
- a rise that is cut short mid-count by a one-clock dropout, which separates a counter that restarts from one that merely pauses;
- a rise after a power-down lock, which shows that the lock exits through a full fresh count.

The power-down bit is applied in two ways. With the strap clear, the same-cycle drop and the long hold that follows show that the lock ignores the bit returning low. With the strap set, reset is seen to stay high, and a supply loss is then seen to still pull reset low. A switch-off pulse several clocks long checks the two-edge NMI latency in both directions.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    typedef enum logic [1:0] {
        PS_OFF   = 2'd0,
        PS_COUNT = 2'd1,
        PS_RUN   = 2'd2,
        PS_LOCK  = 2'd3
    } pwr_state_e;

    typedef struct packed {
        pwr_state_e state;
    } pwr_regs_t;

endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_i};
        end
    end

    assign q_o = chain_q[LAST];
endmodule

// File: rtl/pwr_delay_ctr.sv
module pwr_delay_ctr #(
    parameter int DELAY_CYCLES = 4096
) (
    input  logic clk,
    input  logic arst_n,
    input  logic clr_i,
    input  logic en_i,
    output logic done_o
);
    localparam int CW = $clog2(DELAY_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(DELAY_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    assign done_o = (cnt_q == LAST);

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (en_i && !done_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/pwr_seq_rst.sv
module pwr_seq_rst
    import pwr_seq_pkg::*;
#(
    parameter int DELAY_CYCLES = 4096,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic arst_n,
    input  logic supply_ok_i,
    input  logic pwr_sw_on_i,
    input  logic sw_pd_i,
    input  logic diag_strap_i,
    output logic cpu_rst_no,
    output logic nmi_no
);
    logic [1:0] raw_in;
    logic [1:0] synced;
    logic       sok_s;
    logic       sw_s;
    logic       timer_done;
    logic       pd_fire;
    pwr_regs_t  regs_d;
    pwr_regs_t  regs_q;

    assign raw_in = {pwr_sw_on_i, supply_ok_i};

    pwr_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .arst_n (arst_n),
        .d_i    (raw_in),
        .q_o    (synced)
    );

    assign sok_s = synced[0];
    assign sw_s  = synced[1];

    pwr_delay_ctr #(
        .DELAY_CYCLES (DELAY_CYCLES)
    ) u_delay (
        .clk    (clk),
        .arst_n (arst_n),
        .clr_i  (regs_q.state != PS_COUNT),
        .en_i   (regs_q.state == PS_COUNT),
        .done_o (timer_done)
    );

    // Firmware power-down request, masked by the diagnostic strap.
    assign pd_fire = sw_pd_i & ~diag_strap_i;

    always_comb begin
        regs_d = regs_q;
        unique case (regs_q.state)
            PS_OFF: begin
                if (sok_s) regs_d.state = PS_COUNT;
            end
            PS_COUNT: begin
                if (!sok_s)          regs_d.state = PS_OFF;
                else if (timer_done) regs_d.state = PS_RUN;
            end
            PS_RUN: begin
                if (!sok_s)       regs_d.state = PS_OFF;
                else if (pd_fire) regs_d.state = PS_LOCK;
            end
            PS_LOCK: begin
                if (!sok_s) regs_d.state = PS_OFF;
            end
            default: regs_d.state = PS_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    // Reset drops in the same cycle the power-down bit is raised.
    assign cpu_rst_no = (regs_q.state == PS_RUN) & ~pd_fire;
    assign nmi_no     = ~((regs_q.state == PS_RUN) & ~sw_s);
endmodule

// File: rtl/pwr_seq_rst_chk.sv
module pwr_seq_rst_chk
    import pwr_seq_pkg::*;
(
    input logic       clk,
    input logic       arst_n,
    input logic       sok_s,
    input pwr_state_e state_q,
    input logic       sw_pd_i,
    input logic       diag_strap_i,
    input logic       timer_done,
    input logic       cpu_rst_no
);
    // R2
    release_after_count_chk: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(cpu_rst_no) |-> $past(timer_done));

    // R5
    pd_forces_reset_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (state_q == PS_RUN && sok_s && sw_pd_i && !diag_strap_i) |=> !cpu_rst_no);

    // R6
    lock_holds_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (state_q == PS_LOCK && sok_s) |=> !cpu_rst_no);

    // R8
    diag_keeps_run_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (cpu_rst_no && diag_strap_i && sok_s) |=> (state_q == PS_RUN));

    // R9
    supply_loss_reset_chk: assert property (@(posedge clk) disable iff (!arst_n)
        !sok_s |=> !cpu_rst_no);
endmodule

bind pwr_seq_rst pwr_seq_rst_chk u_chk (
    .clk          (clk),
    .arst_n       (arst_n),
    .sok_s        (sok_s),
    .state_q      (regs_q.state),
    .sw_pd_i      (sw_pd_i),
    .diag_strap_i (diag_strap_i),
    .timer_done   (timer_done),
    .cpu_rst_no   (cpu_rst_no)
);

// File: tb/pwr_seq_rst_bench.sv
`timescale 1ns/1ps
module pwr_seq_rst_bench;
    localparam int DLY = 16;

    typedef struct {
        string req;
        logic  rst;
        logic  nmi;
    } exp_t;

    logic clk = 1'b0;
    logic arst_n = 1'b0;
    logic supply_ok_i = 1'b0;
    logic pwr_sw_on_i = 1'b1;
    logic sw_pd_i = 1'b0;
    logic diag_strap_i = 1'b0;
    logic cpu_rst_no;
    logic nmi_no;

    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    pwr_seq_rst #(.DELAY_CYCLES(DLY)) u_pwr_seq_rst (
        .clk          (clk),
        .arst_n       (arst_n),
        .supply_ok_i  (supply_ok_i),
        .pwr_sw_on_i  (pwr_sw_on_i),
        .sw_pd_i      (sw_pd_i),
        .diag_strap_i (diag_strap_i),
        .cpu_rst_no   (cpu_rst_no),
        .nmi_no       (nmi_no)
    );

    task automatic check(string req, string what, logic act, logic expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, expv, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // Driver: expectation for the state after the coming rising edge.
    task automatic tick(string req, logic r, logic n);
        exp_t e;
        e.req = req;
        e.rst = r;
        e.nmi = n;
        exp_q.push_back(e);
        @(negedge clk);
    endtask

    task automatic powerup(string req);
        supply_ok_i = 1'b1;
        for (int i = 1; i <= DLY + 2; i++) tick(req, 1'b0, 1'b1);
        tick(req, 1'b1, 1'b1);
    endtask

    // Monitor: compares the queue head shortly after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.req, "cpu_rst_no", cpu_rst_no, e.rst);
                check(e.req, "nmi_no", nmi_no, e.nmi);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: held in reset
        check("R1", "cpu_rst_no", cpu_rst_no, 1'b0);
        check("R1", "nmi_no", nmi_no, 1'b1);
        arst_n = 1'b1;
        for (int i = 0; i < 3; i++) tick("R1", 1'b0, 1'b1);

        // R2: clean power-up delay
        powerup("R2");

        // R4: switch-off request
        pwr_sw_on_i = 1'b0;
        tick("R4", 1'b1, 1'b1);
        for (int i = 0; i < 4; i++) tick("R4", 1'b1, 1'b0);
        pwr_sw_on_i = 1'b1;
        tick("R4", 1'b1, 1'b0);
        tick("R4", 1'b1, 1'b1);

        // R9: supply loss while running
        supply_ok_i = 1'b0;
        tick("R9", 1'b1, 1'b1);
        tick("R9", 1'b1, 1'b1);
        tick("R9", 1'b0, 1'b1);
        tick("R9", 1'b0, 1'b1);

        // R3: partial count, one-clock dropout, full restart
        supply_ok_i = 1'b1;
        for (int i = 0; i < 8; i++) tick("R3", 1'b0, 1'b1);
        supply_ok_i = 1'b0;
        tick("R3", 1'b0, 1'b1);
        powerup("R3");

        // R5: immediate effect of the power-down bit
        sw_pd_i = 1'b1;
        #1;
        check("R5", "cpu_rst_no", cpu_rst_no, 1'b0);
        tick("R5", 1'b0, 1'b1);

        // R6: lock persists after the bit clears, supply still good
        sw_pd_i = 1'b0;
        for (int i = 0; i < 3 * DLY; i++) tick("R6", 1'b0, 1'b1);

        // R7: discharge then fresh full sequence
        supply_ok_i = 1'b0;
        for (int i = 0; i < 4; i++) tick("R7", 1'b0, 1'b1);
        powerup("R7");

        // R8: strap blocks the power-down path
        diag_strap_i = 1'b1;
        sw_pd_i = 1'b1;
        #1;
        check("R8", "cpu_rst_no", cpu_rst_no, 1'b1);
        for (int i = 0; i < 2 * DLY; i++) tick("R8", 1'b1, 1'b1);
        sw_pd_i = 1'b0;
        tick("R8", 1'b1, 1'b1);

        // R9: supply loss still resets with the strap set
        supply_ok_i = 1'b0;
        tick("R9", 1'b1, 1'b1);
        tick("R9", 1'b1, 1'b1);
        tick("R9", 1'b0, 1'b1);
        tick("R9", 1'b0, 1'b1);
        diag_strap_i = 1'b0;

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule